// File: doc/BRIEF.md
# Tournament Branch Direction Predictor

This block predicts whether a conditional branch is taken. Two independent component predictors each give a direction. The local component keeps a short history per branch, selected by PC bits, and uses that history to index a table of 3-bit counters. The global component uses one shared shift register of recent outcomes to index a table of 2-bit counters. A third table of 2-bit selector counters shares the global index and decides which component to trust. The prediction port is purely combinational from registered state. It returns the final direction, both component directions and the selector decision.

When a branch resolves, the pipeline presents the PC, the real outcome and the two component directions that were reported for it. All tables and both history stores are trained in that cycle. History advances only at resolution, and no speculative history is kept.

Top module: `tourney_pred`

## Requirements
- R1: After reset every prediction output is 0 for any PC. All counters start at the weakly not-taken value, which is 3 for 3-bit counters and 1 for 2-bit counters. All histories start at zero.
- R2: A counter predicts taken exactly when its most significant bit is 1.
- R3: The local history entry is selected by `pc[PC_LSB +: LH_IDX_W]`. Each valid update shifts the outcome into bit 0 of the entry for `upd_pc_i` and drops the oldest bit.
- R4: A local counter is indexed by the local history of the branch. On each valid update, the counter at the updating branch's current history moves one step toward the outcome and saturates at 0 and 7.
- R5: A global counter is indexed by the global history register. Each valid update moves the counter at the current global history one step toward the outcome, saturating at 0 and 3.
- R6: Each valid update shifts the outcome into bit 0 of the global history register.
- R7: A selector counter in its upper half selects the global component, and in its lower half it selects the local component. It is trained only when `upd_local_i` and `upd_global_i` differ. It moves up when `upd_global_i` equals the outcome and down otherwise, saturating at 0 and 3.
- R8: `pred_taken_o` equals the component direction that the selector picks.
- R9: A prediction made in the same cycle as an update to the same entries returns the values from before that update.
- R10: While `upd_valid_i` is 0, no table or history changes, whatever the other update inputs carry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pred_pc_i | input | PC_W | PC of the branch being predicted |
| pred_taken_o | output | 1 | Final direction, 1 = taken |
| pred_local_o | output | 1 | Local component direction |
| pred_global_o | output | 1 | Global component direction |
| pred_use_global_o | output | 1 | 1 when the selector picks the global component |
| upd_valid_i | input | 1 | A resolved branch is presented |
| upd_pc_i | input | PC_W | PC of the resolved branch |
| upd_taken_i | input | 1 | Actual outcome |
| upd_local_i | input | 1 | Local direction reported at prediction time |
| upd_global_i | input | 1 | Global direction reported at prediction time |

## Verification
The hardest behaviour to reach is a selector counter at its saturated ends. That only happens after a run of updates in which the two components disagree and the same one is right each time, all while the global history keeps returning to the same value. A counter at its saturated end shows at the ports only through the selector output. The bench uses a small configuration with 3-bit histories, so every index repeats often. It alternates phases of heavily biased outcomes with phases of random ones, and it supplies random component directions, so disagreements are frequent. A reference model computes the expected outputs from the rules, and every output is compared in every cycle. Cycles where the predicted and updated branch share an entry are tagged so the old-value rule is checked there.

// File: rtl/tp_pkg.sv
package tp_pkg;
  typedef enum logic {
    SEL_LOCAL  = 1'b0,
    SEL_GLOBAL = 1'b1
  } sel_e;
endpackage

// File: rtl/tp_hist_table.sv
module tp_hist_table #(
  parameter int IDX_W  = 10,
  parameter int HIST_W = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [IDX_W-1:0]  rd_idx_i,
  output logic [HIST_W-1:0] rd_hist_o,
  input  logic [IDX_W-1:0]  wr_idx_i,
  output logic [HIST_W-1:0] wr_hist_o,
  input  logic              wr_en_i,
  input  logic              wr_bit_i
);
  localparam int DEPTH = 1 << IDX_W;

  logic [HIST_W-1:0] mem [DEPTH];

  assign rd_hist_o = mem[rd_idx_i];
  assign wr_hist_o = mem[wr_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= {wr_hist_o[HIST_W-2:0], wr_bit_i};
    end
  end

  // R3: newest outcome lands in bit 0, older bits move up
  a_r3_hist_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem[$past(wr_idx_i)] == {$past(wr_hist_o[HIST_W-2:0]), $past(wr_bit_i)});

  a_r10_hist_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> mem[$past(rd_idx_i)] == $past(rd_hist_o));
endmodule

// File: rtl/tp_ctr_table.sv
module tp_ctr_table #(
  parameter int IDX_W = 12,
  parameter int CTR_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IDX_W-1:0] rd_idx_i,
  output logic             rd_taken_o,
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  logic             wr_up_i
);
  localparam int DEPTH = 1 << IDX_W;
  localparam logic [CTR_W-1:0] CTR_MAX  = '1;
  localparam logic [CTR_W-1:0] CTR_MIN  = '0;
  localparam logic [CTR_W-1:0] CTR_INIT = {1'b0, {(CTR_W-1){1'b1}}};

  logic [CTR_W-1:0] mem [DEPTH];
  logic [CTR_W-1:0] cur_q, nxt_d;

  assign rd_taken_o = mem[rd_idx_i][CTR_W-1];
  assign cur_q      = mem[wr_idx_i];

  always_comb begin
    nxt_d = cur_q;
    if (wr_up_i && cur_q != CTR_MAX) nxt_d = cur_q + 1'b1;
    else if (!wr_up_i && cur_q != CTR_MIN) nxt_d = cur_q - 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= CTR_INIT;
    end else if (wr_en_i) begin
      mem[wr_idx_i] <= nxt_d;
    end
  end

  // R4, R5, R7: saturation at both ends
  a_r5_sat_hi: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && wr_up_i && cur_q == CTR_MAX) |=> mem[$past(wr_idx_i)] == CTR_MAX);
  a_r5_sat_lo: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && !wr_up_i && cur_q == CTR_MIN) |=> mem[$past(wr_idx_i)] == CTR_MIN);
  a_r10_ctr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> mem[$past(rd_idx_i)] == $past(mem[rd_idx_i]));
endmodule

// File: rtl/tourney_pred.sv
module tourney_pred
  import tp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int LH_IDX_W = 10,
  parameter int LHIST_W  = 10,
  parameter int LCTR_W   = 3,
  parameter int GHIST_W  = 12,
  parameter int GCTR_W   = 2,
  parameter int CCTR_W   = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [PC_W-1:0] pred_pc_i,
  output logic            pred_taken_o,
  output logic            pred_local_o,
  output logic            pred_global_o,
  output logic            pred_use_global_o,
  input  logic            upd_valid_i,
  input  logic [PC_W-1:0] upd_pc_i,
  input  logic            upd_taken_i,
  input  logic            upd_local_i,
  input  logic            upd_global_i
);
  logic [LH_IDX_W-1:0] pred_lh_idx, upd_lh_idx;
  logic [LHIST_W-1:0]  pred_lhist, upd_lhist;
  logic [GHIST_W-1:0]  ghr_q;
  logic                sel_train, sel_up;
  sel_e                sel;

  assign pred_lh_idx = pred_pc_i[PC_LSB +: LH_IDX_W];
  assign upd_lh_idx  = upd_pc_i[PC_LSB +: LH_IDX_W];

  tp_hist_table #(.IDX_W(LH_IDX_W), .HIST_W(LHIST_W)) i_lhist (
    .clk_i, .rst_ni,
    .rd_idx_i  (pred_lh_idx),
    .rd_hist_o (pred_lhist),
    .wr_idx_i  (upd_lh_idx),
    .wr_hist_o (upd_lhist),
    .wr_en_i   (upd_valid_i),
    .wr_bit_i  (upd_taken_i)
  );

  tp_ctr_table #(.IDX_W(LHIST_W), .CTR_W(LCTR_W)) i_lctr (
    .clk_i, .rst_ni,
    .rd_idx_i   (pred_lhist),
    .rd_taken_o (pred_local_o),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (upd_lhist),
    .wr_up_i    (upd_taken_i)
  );

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(GCTR_W)) i_gctr (
    .clk_i, .rst_ni,
    .rd_idx_i   (ghr_q),
    .rd_taken_o (pred_global_o),
    .wr_en_i    (upd_valid_i),
    .wr_idx_i   (ghr_q),
    .wr_up_i    (upd_taken_i)
  );

  // selector trains only on disagreement, toward the correct component
  assign sel_train = upd_valid_i && (upd_local_i != upd_global_i);
  assign sel_up    = (upd_global_i == upd_taken_i);

  tp_ctr_table #(.IDX_W(GHIST_W), .CTR_W(CCTR_W)) i_cctr (
    .clk_i, .rst_ni,
    .rd_idx_i   (ghr_q),
    .rd_taken_o (pred_use_global_o),
    .wr_en_i    (sel_train),
    .wr_idx_i   (ghr_q),
    .wr_up_i    (sel_up)
  );

  assign sel          = sel_e'(pred_use_global_o);
  assign pred_taken_o = (sel == SEL_GLOBAL) ? pred_global_o : pred_local_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          ghr_q <= '0;
    else if (upd_valid_i) ghr_q <= {ghr_q[GHIST_W-2:0], upd_taken_i};
  end

  a_r6_ghr_shift: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_valid_i |=> (ghr_q[0] == $past(upd_taken_i)) &&
                    (ghr_q[GHIST_W-1:1] == $past(ghr_q[GHIST_W-2:0])));
  a_r10_ghr_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_valid_i |=> $stable(ghr_q));
endmodule

// File: tb/test_tourney_pred.sv
`timescale 1ns/1ps
module test_tourney_pred;
  localparam int PC_W = 8, PC_LSB = 2, LHI = 2, LHW = 3, GHW = 3;
  localparam int NLH = 1 << LHI, NLC = 1 << LHW, NG = 1 << GHW;

  logic clk = 0, rst_ni = 0;
  logic [PC_W-1:0] pred_pc = '0, upd_pc = '0;
  logic upd_valid = 0, upd_taken = 0, upd_local = 0, upd_global = 0;
  logic p_taken, p_local, p_global, p_use_g;
  int n_run = 0, n_fail = 0;
  bit done = 0;

  int m_lh [NLH];
  int m_lc [NLC];
  int m_gc [NG];
  int m_cc [NG];
  int m_ghr;

  always #2 clk = ~clk;

  tourney_pred #(.PC_W(PC_W), .PC_LSB(PC_LSB), .LH_IDX_W(LHI), .LHIST_W(LHW),
                 .LCTR_W(3), .GHIST_W(GHW), .GCTR_W(2), .CCTR_W(2)) i_tourney_pred (
    .clk_i(clk), .rst_ni(rst_ni), .pred_pc_i(pred_pc),
    .pred_taken_o(p_taken), .pred_local_o(p_local), .pred_global_o(p_global),
    .pred_use_global_o(p_use_g), .upd_valid_i(upd_valid), .upd_pc_i(upd_pc),
    .upd_taken_i(upd_taken), .upd_local_i(upd_local), .upd_global_i(upd_global));

  task automatic chk(input string tag, input logic act, input logic exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %0b expected %0b", tag, act, exp);
    end
  endtask

  function automatic int sat(input int v, input bit up, input int mx);
    if (up) return (v < mx) ? v + 1 : v;
    return (v > 0) ? v - 1 : v;
  endfunction

  function automatic int lidx(input logic [PC_W-1:0] pc);
    return int'(pc[PC_LSB +: LHI]);
  endfunction

  task automatic model_reset();
    for (int i = 0; i < NLH; i++) m_lh[i] = 0;
    for (int i = 0; i < NLC; i++) m_lc[i] = 3;
    for (int i = 0; i < NG; i++) begin m_gc[i] = 1; m_cc[i] = 1; end
    m_ghr = 0;
  endtask

  task automatic model_update();
    int li, h;
    if (!upd_valid) return;
    li = lidx(upd_pc);
    h = m_lh[li];
    m_lc[h] = sat(m_lc[h], upd_taken, 7);
    m_gc[m_ghr] = sat(m_gc[m_ghr], upd_taken, 3);
    if (upd_local != upd_global) m_cc[m_ghr] = sat(m_cc[m_ghr], upd_global == upd_taken, 3);
    m_lh[li] = ((h << 1) | int'(upd_taken)) & (NLC - 1);
    m_ghr = ((m_ghr << 1) | int'(upd_taken)) & (NG - 1);
  endtask

  task automatic compare(input string extra);
    bit el, eg, es;
    el = m_lc[m_lh[lidx(pred_pc)]] >= 4;
    eg = m_gc[m_ghr] >= 2;
    es = m_cc[m_ghr] >= 2;
    chk({"R3 R4", extra}, p_local, el);
    chk({"R5 R6", extra}, p_global, eg);
    chk({"R7", extra}, p_use_g, es);
    chk({"R2 R8", extra}, p_taken, es ? eg : el);
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    // R1: reset state for every PC
    for (int pc = 0; pc < (1 << PC_W); pc += 4) begin
      pred_pc = pc[PC_W-1:0];
      #0.5;
      chk("R1 local", p_local, 1'b0);
      chk("R1 global", p_global, 1'b0);
      chk("R1 select", p_use_g, 1'b0);
      chk("R1 taken", p_taken, 1'b0);
    end
    @(negedge clk);
    rst_ni = 1;

    for (int step = 0; step < 6000; step++) begin
      int phase;
      @(negedge clk);
      phase = (step / 300) % 4;
      pred_pc = PC_W'($urandom);
      upd_pc = PC_W'($urandom);
      upd_valid = ($urandom % 4) != 0;
      case (phase)
        1: upd_taken = ($urandom % 16) != 0;
        2: upd_taken = ($urandom % 16) == 0;
        default: upd_taken = $urandom % 2;
      endcase
      // phase 3: keep the global component right on every disagreement
      upd_local = $urandom % 2;
      upd_global = (phase == 3) ? upd_taken : 1'($urandom % 2);
      #0.5;
      if (upd_valid && lidx(pred_pc) == lidx(upd_pc)) compare(" R9");
      else compare("");
      model_update();
    end

    // R10: update fields toggle with valid low; nothing may move
    for (int step = 0; step < 64; step++) begin
      @(negedge clk);
      upd_valid = 0;
      pred_pc = PC_W'(step * 4);
      upd_pc = PC_W'($urandom);
      upd_taken = $urandom % 2;
      upd_local = $urandom % 2;
      upd_global = $urandom % 2;
      #0.5;
      compare(" R10");
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule